// File: doc/BRIEF.md
# APB3 Address Decoder

This block sits between one APB3 host and a set of APB3 child completers, each of which owns a contiguous address window. The host talks to the block as if it were a single completer. The block compares the incoming address against a fixed base and size for each child. It steers the select to the child whose window holds the address, and it passes the selected child's response back to the host.

The address, the enable strobe and the write data are copied to every child unchanged. Each child sees its direction line high only when it is the target of a write. The whole path is combinational, so a transfer costs exactly the wait states that the addressed child inserts.

An address that falls in no window does not hang the bus. The block completes it at once, with zero read data and an error in the access phase.

Top module: `apbdec_top`

## Requirements
- R1: Child i is selected (its `m_psel` bit high) when `s_psel` is high and `BASE_i <= s_paddr < BASE_i + SIZE_i`; the last address of a window selects it and the first address past it does not; at most one `m_psel` bit is ever high.
- R2: When windows overlap, the child with the lowest index wins the address.
- R3: A child's `m_pwrite` bit is high only while that child is selected for a write (`s_pwrite` high); it is low on reads and for every child that is not selected.
- R4: Every child's `m_penable` bit equals `s_penable` in every cycle, whether or not any child is selected.
- R5: Every child's slice of `m_paddr` equals `s_paddr` and every slice of `m_pwdata` equals `s_pwdata`; child i uses bits `[i*AW +: AW]` and `[i*DW +: DW]`.
- R6: While a child is selected, `s_pready`, `s_pslverr` and `s_prdata` equal that child's `m_pready`, `m_pslverr` and `m_prdata` slice in the same cycle, so a child holding ready low stretches the host transfer cycle for cycle.
- R7: When `s_psel` is high and the address is in no window, no child is selected, `s_pready` is high, `s_prdata` is zero, and `s_pslverr` equals `s_penable` (error in the access phase only).
- R8: When `s_psel` is low, no child is selected and `s_pready`, `s_pslverr` and `s_prdata` are all zero.
- R9: While a transfer moves from setup to access with a stable address, the child select does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | APB reset, active low |
| s_psel | input | 1 | Host select |
| s_penable | input | 1 | Host access-phase strobe |
| s_pwrite | input | 1 | Host direction, high for write |
| s_paddr | input | AW | Host address |
| s_pwdata | input | DW | Host write data |
| s_pready | output | 1 | Ready to host |
| s_pslverr | output | 1 | Error to host |
| s_prdata | output | DW | Read data to host |
| m_psel | output | N | Per-child select |
| m_penable | output | N | Per-child enable |
| m_pwrite | output | N | Per-child direction |
| m_paddr | output | N*AW | Per-child address, packed |
| m_pwdata | output | N*DW | Per-child write data, packed |
| m_pready | input | N | Per-child ready |
| m_pslverr | input | N | Per-child error |
| m_prdata | input | N*DW | Per-child read data, packed |

## Verification
Lowest-index priority is the hardest case to reach, because the default parameters place the windows apart and so no host address can land in two of them. The bench therefore builds a second instance with narrow widths and two overlapping windows. It probes an address inside the shared span and one address on each side of it. The unmapped response and child wait states are reached by holding a transfer in its access phase while the bench-driven child ready stays low, then checking the host side in each of those cycles.

// File: rtl/apbdec_pkg.sv
package apbdec_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } apb_phase_e;

    function automatic apb_phase_e phase_of(input logic sel, input logic en);
        if (!sel)    return PH_IDLE;
        else if (en) return PH_ACCESS;
        else         return PH_SETUP;
    endfunction

endpackage

// File: rtl/apbdec_match.sv
module apbdec_match #(
    parameter int            AW   = 32,
    parameter logic [AW-1:0] BASE = '0,
    parameter logic [AW-1:0] SIZE = '0
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    logic          above_base;
    logic [AW-1:0] offset;

    always_comb begin
        above_base = (addr >= BASE);
        offset     = addr - BASE;
        hit        = above_base && (offset < SIZE);
    end
endmodule

// File: rtl/apbdec_prio.sv
module apbdec_prio #(
    parameter int N = 4
) (
    input  logic [N-1:0] hit,
    output logic [N-1:0] grant
);
    logic taken;

    always_comb begin
        grant = '0;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (hit[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/apbdec_rmux.sv
module apbdec_rmux #(
    parameter int N  = 4,
    parameter int DW = 32
) (
    input  logic [N-1:0]    grant,
    input  logic [N-1:0]    ready_in,
    input  logic [N-1:0]    err_in,
    input  logic [N*DW-1:0] data_in,
    output logic            any,
    output logic            ready,
    output logic            err,
    output logic [DW-1:0]   data
);
    always_comb begin
        any   = |grant;
        ready = |(grant & ready_in);
        err   = |(grant & err_in);
        data  = '0;
        for (int i = 0; i < N; i++) begin
            data = data | ({DW{grant[i]}} & data_in[i*DW +: DW]);
        end
    end
endmodule

// File: rtl/apbdec_top.sv
module apbdec_top
    import apbdec_pkg::*;
#(
    parameter int              N     = 4,
    parameter int              AW    = 32,
    parameter int              DW    = 32,
    parameter logic [N*AW-1:0] BASES = {32'h0000_4000, 32'h0000_2000, 32'h0000_1000, 32'h0000_0000},
    parameter logic [N*AW-1:0] SIZES = {32'h0000_1000, 32'h0000_1000, 32'h0000_1000, 32'h0000_1000}
) (
    input  logic            pclk,
    input  logic            presetn,
    input  logic            s_psel,
    input  logic            s_penable,
    input  logic            s_pwrite,
    input  logic [AW-1:0]   s_paddr,
    input  logic [DW-1:0]   s_pwdata,
    output logic            s_pready,
    output logic            s_pslverr,
    output logic [DW-1:0]   s_prdata,
    output logic [N-1:0]    m_psel,
    output logic [N-1:0]    m_penable,
    output logic [N-1:0]    m_pwrite,
    output logic [N*AW-1:0] m_paddr,
    output logic [N*DW-1:0] m_pwdata,
    input  logic [N-1:0]    m_pready,
    input  logic [N-1:0]    m_pslverr,
    input  logic [N*DW-1:0] m_prdata
);
    typedef struct packed {
        logic          ready;
        logic          err;
        logic [DW-1:0] data;
    } host_rsp_t;

    logic [N-1:0]  hit, grant, wr_sel, rd_sel;
    logic          mux_any, mux_ready, mux_err;
    logic [DW-1:0] mux_data;
    apb_phase_e    phase;
    host_rsp_t     rsp_d;

    // Window compare, one per child
    for (genvar g = 0; g < N; g++) begin : g_win
        apbdec_match #(
            .AW  (AW),
            .BASE(BASES[g*AW +: AW]),
            .SIZE(SIZES[g*AW +: AW])
        ) u_match (
            .addr(s_paddr),
            .hit (hit[g])
        );
    end

    apbdec_prio #(.N(N)) u_prio (
        .hit  (hit),
        .grant(grant)
    );

    // Separate decoded selects per direction
    always_comb begin
        wr_sel = grant & {N{s_psel &  s_pwrite}};
        rd_sel = grant & {N{s_psel & ~s_pwrite}};
    end

    assign m_psel    = wr_sel | rd_sel;
    assign m_pwrite  = wr_sel;
    assign m_penable = {N{s_penable}};
    assign m_paddr   = {N{s_paddr}};
    assign m_pwdata  = {N{s_pwdata}};

    apbdec_rmux #(.N(N), .DW(DW)) u_rmux (
        .grant   (grant),
        .ready_in(m_pready),
        .err_in  (m_pslverr),
        .data_in (m_prdata),
        .any     (mux_any),
        .ready   (mux_ready),
        .err     (mux_err),
        .data    (mux_data)
    );

    // Host response: zero when idle, child when mapped, error-complete otherwise
    always_comb begin
        phase = phase_of(s_psel, s_penable);
        rsp_d = '0;
        if (phase != PH_IDLE) begin
            if (mux_any) begin
                rsp_d.ready = mux_ready;
                rsp_d.err   = mux_err;
                rsp_d.data  = mux_data;
            end else begin
                rsp_d.ready = 1'b1;
                rsp_d.err   = (phase == PH_ACCESS);
            end
        end
    end

    assign s_pready  = rsp_d.ready;
    assign s_pslverr = rsp_d.err;
    assign s_prdata  = rsp_d.data;

    // R1: never more than one child selected
    a_r1_one_child: assert property (@(posedge pclk) disable iff (!presetn)
        $onehot0(m_psel));

    // R3: a host read drives no child direction line
    a_r3_read_no_write: assert property (@(posedge pclk) disable iff (!presetn)
        (s_psel && !s_pwrite) |-> (m_pwrite == '0));

    // R4: enable reaches every child
    a_r4_enable_fanout: assert property (@(posedge pclk) disable iff (!presetn)
        (m_penable == {N{s_penable}}));

    // R7: unmapped access completes with error and zero data
    a_r7_unmapped: assert property (@(posedge pclk) disable iff (!presetn)
        (s_psel && s_penable && (m_psel == '0)) |-> (s_pready && s_pslverr && (s_prdata == '0)));

    // R8: idle host bus gives an all-zero response
    a_r8_idle_zero: assert property (@(posedge pclk) disable iff (!presetn)
        !s_psel |-> (!s_pready && !s_pslverr && (s_prdata == '0) && (m_psel == '0)));

    // R9: select held from setup into access
    a_r9_sel_steady: assert property (@(posedge pclk) disable iff (!presetn)
        ($past(s_psel && !s_penable) && s_psel && s_penable && $stable(s_paddr)) |-> $stable(m_psel));

    // R6: host ready tracks the selected child
    for (genvar k = 0; k < N; k++) begin : g_chk
        a_r6_ready_follow: assert property (@(posedge pclk) disable iff (!presetn)
            m_psel[k] |-> ((s_pready == m_pready[k]) && (s_prdata == m_prdata[k*DW +: DW])));
    end
endmodule

// File: tb/tb_apbdec_top.sv
`timescale 1ns/1ps
module tb_apbdec_top;
    logic clk = 1'b0;
    logic rstn = 1'b0;
    always #2 clk = ~clk;

    logic        psel = 0, pen = 0, pwr = 0;
    logic [31:0] paddr = 0, pwdata = 0;
    logic        s_pready, s_pslverr;
    logic [31:0] s_prdata;
    logic [3:0]  m_psel, m_pen, m_pwr;
    logic [127:0] m_paddr, m_pwdata;
    logic [3:0]  child_rdy = 4'hF;
    logic [3:0]  child_err = 4'b0100;
    logic [127:0] child_data = {32'hA500_0030, 32'hA500_0020, 32'hA500_0010, 32'hA500_0000};

    apbdec_top dut (
        .pclk(clk), .presetn(rstn),
        .s_psel(psel), .s_penable(pen), .s_pwrite(pwr), .s_paddr(paddr), .s_pwdata(pwdata),
        .s_pready(s_pready), .s_pslverr(s_pslverr), .s_prdata(s_prdata),
        .m_psel(m_psel), .m_penable(m_pen), .m_pwrite(m_pwr), .m_paddr(m_paddr), .m_pwdata(m_pwdata),
        .m_pready(child_rdy), .m_pslverr(child_err), .m_prdata(child_data)
    );

    // Overlapping windows: child0 0x100..0x1FF, child1 0x180..0x27F
    logic        ov_psel = 0;
    logic [15:0] ov_addr = 0;
    logic        ov_ready, ov_err;
    logic [7:0]  ov_rdata;
    logic [1:0]  ov_msel, ov_men, ov_mwr;
    logic [31:0] ov_maddr;
    logic [15:0] ov_mwdata;

    apbdec_top #(
        .N(2), .AW(16), .DW(8),
        .BASES({16'h0180, 16'h0100}),
        .SIZES({16'h0100, 16'h0100})
    ) dut_ov (
        .pclk(clk), .presetn(rstn),
        .s_psel(ov_psel), .s_penable(1'b0), .s_pwrite(1'b0), .s_paddr(ov_addr), .s_pwdata(8'h00),
        .s_pready(ov_ready), .s_pslverr(ov_err), .s_prdata(ov_rdata),
        .m_psel(ov_msel), .m_penable(ov_men), .m_pwrite(ov_mwr), .m_paddr(ov_maddr), .m_pwdata(ov_mwdata),
        .m_pready(2'b11), .m_pslverr(2'b00), .m_prdata(16'h2211)
    );

    typedef struct {
        string       tag;
        logic [3:0]  psel, pwrite;
        logic        pready, perr, penable;
        logic [31:0] rdata, addr, wdata;
    } item_t;
    item_t q[$];

    int checks = 0, fails = 0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Independent model of the default window map
    function automatic int decode(logic [31:0] a);
        if (a < 32'h1000) return 0;
        if (a < 32'h2000) return 1;
        if (a < 32'h3000) return 2;
        if (a >= 32'h4000 && a < 32'h5000) return 3;
        return -1;
    endfunction

    // Driver: apply one cycle of host stimulus and queue the expectation
    task automatic step(string tag, logic sel, logic en, logic wr, logic [31:0] a,
                        logic [31:0] w, logic [3:0] rdy);
        item_t it;
        int c;
        @(posedge clk); #1;
        psel = sel; pen = en; pwr = wr; paddr = a; pwdata = w; child_rdy = rdy;
        c = sel ? decode(a) : -1;
        it.tag = tag; it.penable = en; it.addr = a; it.wdata = w;
        it.psel = (c >= 0) ? 4'(1 << c) : 4'b0;
        it.pwrite = wr ? it.psel : 4'b0;
        if (!sel) begin
            it.pready = 0; it.perr = 0; it.rdata = 0;
        end else if (c < 0) begin
            it.pready = 1; it.perr = en; it.rdata = 0;
        end else begin
            it.pready = rdy[c]; it.perr = child_err[c];
            it.rdata  = 32'hA500_0000 | (32'(c) << 4);
        end
        q.push_back(it);
    endtask

    // Monitor: compare at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            chk(it.tag, "m_psel",    32'(m_psel),   32'(it.psel));
            chk(it.tag, "m_pwrite",  32'(m_pwr),    32'(it.pwrite));
            chk(it.tag, "s_pready",  32'(s_pready), 32'(it.pready));
            chk(it.tag, "s_pslverr", 32'(s_pslverr),32'(it.perr));
            chk(it.tag, "s_prdata",  s_prdata,      it.rdata);
            for (int i = 0; i < 4; i++) begin
                chk("R4", "m_penable", 32'(m_pen[i]), 32'(it.penable));
                chk("R5", "m_paddr",   m_paddr[i*32 +: 32],  it.addr);
                chk("R5", "m_pwdata",  m_pwdata[i*32 +: 32], it.wdata);
            end
        end
    end

    bit done = 0;
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        // reset state, R8
        @(negedge clk);
        chk("R8", "reset s_pready", 32'(s_pready), 0);
        chk("R8", "reset m_psel",   32'(m_psel),   0);
        repeat (2) @(posedge clk);
        rstn = 1;
        step("R8", 0, 0, 0, 32'h1000, 32'h0, 4'hF);
        step("R8", 0, 1, 1, 32'h2004, 32'h55, 4'hF);
        // R1/R3 write to child1
        step("R1", 1, 0, 1, 32'h1004, 32'hDEAD_BEEF, 4'hF);
        step("R3", 1, 1, 1, 32'h1004, 32'hDEAD_BEEF, 4'hF);
        // R6 read at top of child2 window, child2 reports error
        step("R1", 1, 0, 0, 32'h2FFC, 32'h0, 4'hF);
        step("R6", 1, 1, 0, 32'h2FFC, 32'h0, 4'hF);
        // R6 wait states from child0
        step("R6", 1, 0, 0, 32'h0000, 32'h0, 4'hE);
        step("R6", 1, 1, 0, 32'h0000, 32'h0, 4'hE);
        step("R6", 1, 1, 0, 32'h0000, 32'h0, 4'hE);
        step("R6", 1, 1, 0, 32'h0000, 32'h0, 4'hF);
        // R7 unmapped gap and past the last window
        step("R7", 1, 0, 0, 32'h3000, 32'h0, 4'h0);
        step("R7", 1, 1, 0, 32'h3000, 32'h0, 4'h0);
        step("R7", 1, 0, 1, 32'h5000, 32'h1234, 4'hF);
        step("R7", 1, 1, 1, 32'h5000, 32'h1234, 4'hF);
        // R1 boundaries of child3
        step("R1", 1, 0, 1, 32'h4FFF, 32'h77, 4'hF);
        step("R1", 1, 1, 0, 32'h4000, 32'h0, 4'h7);
        step("R1", 1, 1, 0, 32'h3FFF, 32'h0, 4'hF);
        step("R8", 0, 0, 0, 32'h0, 32'h0, 4'hF);
        @(negedge clk); @(negedge clk);
        // R2 overlap priority
        ov_psel = 1; ov_addr = 16'h01C0;
        @(negedge clk);
        chk("R2", "ov m_psel shared", 32'(ov_msel), 32'h1);
        chk("R2", "ov rdata shared",  32'(ov_rdata), 32'h11);
        ov_addr = 16'h0220;
        @(negedge clk);
        chk("R2", "ov m_psel upper", 32'(ov_msel), 32'h2);
        chk("R2", "ov rdata upper",  32'(ov_rdata), 32'h22);
        ov_addr = 16'h00FF;
        @(negedge clk);
        chk("R7", "ov unmapped sel",   32'(ov_msel), 0);
        chk("R7", "ov unmapped ready", 32'(ov_ready), 1);
        chk("R7", "ov unmapped err",   32'(ov_err), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule